// File: doc/BRIEF.md
# Compressed Table-Jump Execution Unit

This unit executes the 16-bit table-jump instructions of a 32-bit hart. It takes an instruction word, the program counter of that instruction and the current value of the jump-vector-table control register. From these it finds a table slot in memory and issues one instruction-fetch-class read for it. The word that comes back becomes the jump target. One instruction opcode covers two forms, and the index range picks between them: small indices give a plain jump, large indices give a jump that also writes the return address into x1.

The unit sits next to the execute stage. It reports exactly one outcome per accepted instruction: a redirect, with a link write when the linking form was used, an illegal-instruction flag, or an instruction-access-fault flag. Address translation, the control register file, the register file and memory are outside the block. The read goes out over a request/ready handshake and comes back over a response-valid strobe that can carry a fault.

Top module: `tbljmp_unit`

## Requirements
- R1: A word is recognised only when bits[1:0] equal 2'b10 and bits[15:10] equal 6'b101000. Any other word that is accepted produces `illegalInstr` in the cycle after acceptance and issues no memory read.
- R2: When bits[9:7] are zero, the word is the plain jump form, with a 5-bit index in bits[6:2]. It produces `redirectValid` and does not assert `linkWrite`.
- R3: When bits[9:7] are nonzero, the word is the linking form, with an 8-bit index in bits[9:2] that is 32 or greater. Its redirect comes with `linkWrite` and `linkData` = pc+2, truncated to 32 bits.
- R4: When the mode field, control-register bits[5:0], is nonzero, the unit flags `illegalInstr` in the cycle after acceptance. It issues no memory read, no redirect and no link write.
- R5: The read address is {csr[31:6], 6'b0} + index*4, truncated to 32 bits.
- R6: `redirectTarget` is the returned table word with bit 0 forced to zero.
- R7: A response with `memFault` set produces `accessFault`, with no redirect and no link write.
- R8: `busy` is high from the cycle after acceptance until the result cycle ends. Each accepted instruction produces exactly one single-cycle result pulse. `startValid` is ignored while `busy` is high.
- R9: `memReq` and `memAddr` hold steady until `memReady` is seen. After that the unit waits any number of cycles for `memRspValid`, and the result follows in the next cycle.
- R10: After reset, `busy`, `memReq` and every result output are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| startValid | input | 1 | Offers an instruction; taken when not busy |
| instr | input | 16 | Instruction word |
| pc | input | 32 | Address of the instruction |
| vecCsr | input | 32 | Jump-vector-table register: base in [31:6], mode in [5:0] |
| busy | output | 1 | An instruction is in flight |
| memReq | output | 1 | Table read request |
| memAddr | output | 32 | Table slot address |
| memReady | input | 1 | Memory accepts the request |
| memRspValid | input | 1 | Response strobe |
| memData | input | 32 | Returned table word |
| memFault | input | 1 | Response reports an access fault |
| redirectValid | output | 1 | Jump to `redirectTarget` |
| redirectTarget | output | 32 | Jump target, bit 0 cleared |
| linkWrite | output | 1 | Write `linkData` to x1 |
| linkData | output | 32 | Return address pc+2 |
| illegalInstr | output | 1 | Illegal-instruction outcome |
| accessFault | output | 1 | Instruction-access-fault outcome |

## Verification
The hardest state to reach from the ports is a new `startValid` that arrives while a read is still outstanding. If it were taken, it would split one instruction's result into two or swap its outcome. The bench offers a word that does not decode during the response wait and checks that only the original redirect appears. It also holds `memReady` low for several cycles while checking that the request and address stay steady. The wrap-around cases, a top-of-memory table and a pc of 0xFFFFFFFE, are driven as table vectors.

// File: rtl/tbljmp_pkg.sv
package tbljmp_pkg;
  typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_WAIT, ST_DONE} state_t;

  typedef struct packed {
    logic captureOp;
    logic captureRsp;
    logic emit;
  } strobe_t;
endpackage

// File: rtl/tbljmp_ctrl.sv
module tbljmp_ctrl
  import tbljmp_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    startValid,
  input  logic    opLegal,
  input  logic    memReady,
  input  logic    memRspValid,
  output strobe_t strobe,
  output logic    busy,
  output logic    memReq
);
  state_t state;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
    end else begin
      case (state)
        ST_IDLE: if (startValid) state <= opLegal ? ST_REQ : ST_DONE;
        ST_REQ:  if (memReady) state <= ST_WAIT;
        ST_WAIT: if (memRspValid) state <= ST_DONE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    strobe.captureOp  = (state == ST_IDLE) && startValid;
    strobe.captureRsp = (state == ST_WAIT) && memRspValid;
    strobe.emit       = (state == ST_DONE);
  end

  assign busy   = (state != ST_IDLE);
  assign memReq = (state == ST_REQ);

  // R9: request stays up until memory takes it
  assert_req_hold_R9: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memReady |=> memReq);

  // R1 / R4: a refused word never reaches memory
  assert_illegal_skips_mem_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!busy && startValid && !opLegal) |=> !memReq);
endmodule

// File: rtl/tbljmp_dpath.sv
module tbljmp_dpath
  import tbljmp_pkg::*;
#(
  parameter int XLEN     = 32,
  parameter int ILEN     = 16,
  parameter int BASE_LSB = 6,
  parameter int IDX_W    = 8
) (
  input  logic            clk,
  input  logic            rstN,
  input  strobe_t         strobe,
  input  logic [ILEN-1:0] instr,
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] vecCsr,
  input  logic [XLEN-1:0] memData,
  input  logic            memFault,
  output logic            opLegal,
  output logic [XLEN-1:0] memAddr,
  output logic            redirectValid,
  output logic [XLEN-1:0] redirectTarget,
  output logic            linkWrite,
  output logic [XLEN-1:0] linkData,
  output logic            illegalInstr,
  output logic            accessFault
);
  localparam int ENTRY_SHIFT = $clog2(XLEN / 8);
  localparam int IDX_LO      = 2;
  localparam int IDX_HI      = IDX_LO + IDX_W - 1;
  localparam int FORM_LO     = IDX_LO + 5;
  localparam int INSTR_BYTES = ILEN / 8;

  logic            opMatch, modeOk, isLink;
  logic [XLEN-1:0] baseQ, pcQ, targetQ;
  logic [IDX_W-1:0] idxQ;
  logic            linkQ, illegalQ, faultQ;

  always_comb begin
    opMatch = (instr[1:0] == 2'b10) && (instr[ILEN-1:IDX_HI+1] == 6'b101000);
    modeOk  = (vecCsr[BASE_LSB-1:0] == '0);
    opLegal = opMatch && modeOk;
    isLink  = (instr[IDX_HI:FORM_LO] != '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      baseQ    <= '0;
      pcQ      <= '0;
      idxQ     <= '0;
      linkQ    <= 1'b0;
      illegalQ <= 1'b0;
      faultQ   <= 1'b0;
      targetQ  <= '0;
    end else begin
      if (strobe.captureOp) begin
        baseQ    <= {vecCsr[XLEN-1:BASE_LSB], {BASE_LSB{1'b0}}};
        pcQ      <= pc;
        idxQ     <= instr[IDX_HI:IDX_LO];
        linkQ    <= isLink;
        illegalQ <= !opLegal;
        faultQ   <= 1'b0;
      end
      if (strobe.captureRsp) begin
        faultQ  <= memFault;
        targetQ <= memData & ~XLEN'(1);
      end
    end
  end

  assign memAddr        = baseQ + (XLEN'(idxQ) << ENTRY_SHIFT);
  assign linkData       = pcQ + XLEN'(INSTR_BYTES);
  assign redirectTarget = targetQ;
  assign redirectValid  = strobe.emit && !illegalQ && !faultQ;
  assign linkWrite      = redirectValid && linkQ;
  assign illegalInstr   = strobe.emit && illegalQ;
  assign accessFault    = strobe.emit && !illegalQ && faultQ;

  // R8: at most one outcome in any cycle
  assert_one_result_R8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({redirectValid, illegalInstr, accessFault}));

  // R3 / R7: the x1 write never happens without a redirect
  assert_link_needs_redirect_R3: assert property (@(posedge clk) disable iff (!rstN)
    linkWrite |-> redirectValid && !accessFault);
endmodule

// File: rtl/tbljmp_unit.sv
module tbljmp_unit
  import tbljmp_pkg::*;
#(
  parameter int XLEN = 32,
  parameter int ILEN = 16
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            startValid,
  input  logic [ILEN-1:0] instr,
  input  logic [XLEN-1:0] pc,
  input  logic [XLEN-1:0] vecCsr,
  output logic            busy,
  output logic            memReq,
  output logic [XLEN-1:0] memAddr,
  input  logic            memReady,
  input  logic            memRspValid,
  input  logic [XLEN-1:0] memData,
  input  logic            memFault,
  output logic            redirectValid,
  output logic [XLEN-1:0] redirectTarget,
  output logic            linkWrite,
  output logic [XLEN-1:0] linkData,
  output logic            illegalInstr,
  output logic            accessFault
);
  strobe_t strobe;
  logic    opLegal;

  tbljmp_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .startValid(startValid), .opLegal(opLegal),
    .memReady(memReady), .memRspValid(memRspValid),
    .strobe(strobe), .busy(busy), .memReq(memReq)
  );

  tbljmp_dpath #(.XLEN(XLEN), .ILEN(ILEN)) u_dpath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .instr(instr), .pc(pc),
    .vecCsr(vecCsr), .memData(memData), .memFault(memFault),
    .opLegal(opLegal), .memAddr(memAddr),
    .redirectValid(redirectValid), .redirectTarget(redirectTarget),
    .linkWrite(linkWrite), .linkData(linkData),
    .illegalInstr(illegalInstr), .accessFault(accessFault)
  );

  // R9: address steady while the request waits
  assert_addr_stable_R9: assert property (@(posedge clk) disable iff (!rstN)
    memReq && !memReady |=> $stable(memAddr));

  // R8: busy drops only after an outcome was shown
  assert_busy_release_R8: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> $past(redirectValid || illegalInstr || accessFault));
endmodule

// File: tb/sim_tbljmp_unit.sv
`timescale 1ns/1ps
module sim_tbljmp_unit;
  typedef struct packed {
    logic [15:0] instr;
    logic [31:0] pc;
    logic [31:0] csr;
    logic [31:0] entry;
    logic        fault;
    logic [3:0]  lat;
    logic [1:0]  kind;   // 0 jump, 1 jump+link, 2 illegal, 3 access fault
    logic [31:0] addr;
    logic [31:0] target;
    logic [31:0] link;
  } vec_t;

  localparam int NVEC = 11;
  localparam vec_t VECS [NVEC] = '{
    '{16'hA002, 32'h0000_0100, 32'h0001_0000, 32'h8000_1235, 1'b0, 4'd0, 2'd0, 32'h0001_0000, 32'h8000_1234, 32'h0},
    '{16'hA07E, 32'h0000_0100, 32'h0001_0000, 32'h2000_0000, 1'b0, 4'd1, 2'd0, 32'h0001_007C, 32'h2000_0000, 32'h0},
    '{16'hA082, 32'h0000_0200, 32'h0002_0040, 32'h0000_4443, 1'b0, 4'd2, 2'd1, 32'h0002_00C0, 32'h0000_4442, 32'h0000_0202},
    '{16'hA3FE, 32'hFFFF_FFFE, 32'hFFFF_FFC0, 32'hFFFF_FFFF, 1'b0, 4'd0, 2'd1, 32'h0000_03BC, 32'hFFFF_FFFE, 32'h0000_0000},
    '{16'hA002, 32'h0000_0100, 32'h0001_0001, 32'h0,         1'b0, 4'd0, 2'd2, 32'h0,         32'h0,         32'h0},
    '{16'hA082, 32'h0000_0100, 32'h0001_0020, 32'h0,         1'b0, 4'd0, 2'd2, 32'h0,         32'h0,         32'h0},
    '{16'hA003, 32'h0000_0100, 32'h0001_0000, 32'h0,         1'b0, 4'd0, 2'd2, 32'h0,         32'h0,         32'h0},
    '{16'hA402, 32'h0000_0100, 32'h0001_0000, 32'h0,         1'b0, 4'd0, 2'd2, 32'h0,         32'h0,         32'h0},
    '{16'hA082, 32'h0000_0300, 32'h0001_0000, 32'h1234_5678, 1'b1, 4'd3, 2'd3, 32'h0001_0080, 32'h0,         32'h0},
    '{16'hA016, 32'h0000_0300, 32'h0001_0000, 32'h1234_5678, 1'b1, 4'd0, 2'd3, 32'h0001_0014, 32'h0,         32'h0},
    '{16'hA00E, 32'h0000_0400, 32'h0001_0000, 32'h0000_0013, 1'b0, 4'd5, 2'd0, 32'h0001_000C, 32'h0000_0012, 32'h0}
  };

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        startValid = 1'b0;
  logic [15:0] instr = '0;
  logic [31:0] pc = '0, vecCsr = '0;
  logic        busy, memReq, memReady = 1'b0, memRspValid = 1'b0, memFault = 1'b0;
  logic [31:0] memAddr, memData = '0;
  logic        redirectValid, linkWrite, illegalInstr, accessFault;
  logic [31:0] redirectTarget, linkData;

  int nChecks = 0;
  int nErr = 0;

  always #2.5 clk = ~clk;

  tbljmp_unit u0 (
    .clk(clk), .rstN(rstN), .startValid(startValid), .instr(instr), .pc(pc),
    .vecCsr(vecCsr), .busy(busy), .memReq(memReq), .memAddr(memAddr),
    .memReady(memReady), .memRspValid(memRspValid), .memData(memData),
    .memFault(memFault), .redirectValid(redirectValid),
    .redirectTarget(redirectTarget), .linkWrite(linkWrite), .linkData(linkData),
    .illegalInstr(illegalInstr), .accessFault(accessFault)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nErr++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic runOp(input vec_t v, input int stall, input bit poke);
    logic [3:0] res;
    bit got;
    @(negedge clk);
    startValid = 1'b1; instr = v.instr; pc = v.pc; vecCsr = v.csr;
    @(negedge clk);
    startValid = 1'b0; instr = 16'h0;
    check("R8 busy after accept", 32'(busy), 32'd1);
    if (v.kind != 2'd2) begin
      check("R5 request raised", 32'(memReq), 32'd1);
      check("R5 entry address", memAddr, v.addr);
      for (int s = 0; s < stall; s++) begin
        @(negedge clk);
        check("R9 request held", 32'(memReq), 32'd1);
        check("R9 address held", memAddr, v.addr);
      end
      memReady = 1'b1;
      @(negedge clk);
      memReady = 1'b0;
      if (poke) begin
        startValid = 1'b1; instr = 16'hA003;
        @(negedge clk);
        startValid = 1'b0; instr = 16'h0;
      end
      for (int w = 0; w < int'(v.lat); w++) begin
        @(negedge clk);
        check("R9 no early result", 32'({redirectValid, illegalInstr, accessFault}), 32'd0);
      end
      memRspValid = 1'b1; memData = v.entry; memFault = v.fault;
      @(negedge clk);
      memRspValid = 1'b0; memData = '0; memFault = 1'b0;
    end
    got = 1'b0;
    res = '0;
    for (int k = 0; k < 8 && !got; k++) begin
      if (redirectValid || illegalInstr || accessFault) begin
        got = 1'b1;
        res = {redirectValid, linkWrite, illegalInstr, accessFault};
        if (v.kind == 2'd2) check("R4 illegal at once, no read", 32'(k) + 32'(memReq), 32'd0);
        if (v.kind <= 2'd1) check("R6 target", redirectTarget, v.target);
        if (v.kind == 2'd1) check("R3 link data", linkData, v.link);
      end else begin
        @(negedge clk);
      end
    end
    case (v.kind)
      2'd0: check("R2 jump outcome", 32'(res), 32'b1000);
      2'd1: check("R3 link outcome", 32'(res), 32'b1100);
      2'd2: check("R1 R4 illegal outcome", 32'(res), 32'b0010);
      default: check("R7 fault outcome", 32'(res), 32'b0001);
    endcase
    @(negedge clk);
    check("R8 single pulse, idle after", 32'({busy, redirectValid, illegalInstr, accessFault}), 32'd0);
  endtask

  initial begin
    #(200000 * 5);
    nErr++; nChecks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R10 reset outputs", 32'({busy, memReq, redirectValid, linkWrite, illegalInstr, accessFault}), 32'd0);
    rstN = 1'b1;
    @(negedge clk);
    check("R10 idle after reset", 32'({busy, memReq}), 32'd0);

    for (int i = 0; i < NVEC; i++) runOp(VECS[i], 0, 1'b0);

    // R9: long ready stall on a link jump
    runOp(VECS[2], 4, 1'b0);
    // R8: a new offer during the response wait is ignored
    runOp(VECS[0], 1, 1'b1);
    runOp(VECS[3], 0, 1'b1);

    $display("Result: errors=%0d of %0d checks", nErr, nChecks);
    $finish;
  end
endmodule